// File: doc/BRIEF.md
# Pixel Colour Packer with Luminance Option

The block turns one colour sample, given as three 16-bit channel intensities, into the packed word a display panel reads. The conversion takes two stages. The first stage can replace the three channels with a single weighted luminance value, so the output is gray. The second stage cuts each channel down to the width of its field and places the fields in the word. The order of the fields and the word format are chosen for each sample.

Two word formats are supported. The 16-bit format uses fields of 5, 6 and 5 bits. The 24-bit format uses three 8-bit fields. A per-sample order select swaps the red and blue fields. Samples may arrive on every clock cycle. Each sample carries its own mode bits, so the mode can change between two consecutive samples.

Top module: `pixel_packer`

## Requirements
- R1: `pix_vld` is high exactly two clock cycles after `col_vld` was high, and low in every other cycle.
- R2: While `rst_n` is low, `pix_vld` is 0 and `pix_word` is 0.
- R3: When `wide_fmt`=0 and `swap_rb`=0, `pix_word[15:11]` = red[15:11], `pix_word[10:5]` = green[15:10] and `pix_word[4:0]` = blue[15:11].
- R4: When `wide_fmt`=0 and `swap_rb`=1, `pix_word[15:11]` = blue[15:11], `pix_word[10:5]` = green[15:10] and `pix_word[4:0]` = red[15:11].
- R5: When `wide_fmt`=1 and `swap_rb`=0, `pix_word[23:16]` = red[15:8], `pix_word[15:8]` = green[15:8] and `pix_word[7:0]` = blue[15:8].
- R6: When `wide_fmt`=1 and `swap_rb`=1, `pix_word[23:16]` = blue[15:8], `pix_word[15:8]` = green[15:8] and `pix_word[7:0]` = red[15:8].
- R7: When `gray_en`=1, all three channels are replaced by Y = (77·R + 151·G + 28·B) >> 8 before they are truncated and placed. The sum is kept wide enough that all-ones inputs give Y = 0xFFFF.
- R8: In the 16-bit format, `pix_word[23:16]` is 0. No transparency field exists in either format.
- R9: A sample presented with `col_vld`=0 has no effect. `pix_word` keeps its last value in every cycle in which `pix_vld` is low.
- R10: Samples presented on consecutive cycles, each with different mode bits, come out in order on consecutive cycles. Each output is packed with the mode bits of its own sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_vld | input | 1 | Colour sample strobe |
| col_red | input | 16 | Red intensity |
| col_grn | input | 16 | Green intensity |
| col_blu | input | 16 | Blue intensity |
| gray_en | input | 1 | Replace channels by luminance |
| swap_rb | input | 1 | Swap red and blue field positions |
| wide_fmt | input | 1 | 0: 16-bit 565 word, 1: 24-bit 888 word |
| pix_vld | output | 1 | Packed word valid |
| pix_word | output | 24 | Packed pixel word |

## Verification
The luminance stage and the field-placement stage run at the same time on different samples. The overlap that matters is a new sample entering the weighted sum in the same cycle that the previous sample is being truncated and placed. The bench provokes this with a burst of samples on consecutive cycles, each with a different combination of gray, order and format bits. Every output is compared with the value computed from its own sample's settings, so any leak of one sample's mode into its neighbour shows up as a miscompare.

// File: rtl/pixel_packer_pkg.sv
package pixel_packer_pkg;
  parameter int CH_W   = 16;
  parameter int WORD_W = 24;
  parameter int FRAC_W = 8;
  localparam int SUM_W = CH_W + FRAC_W;
  parameter int WT_R = 77;
  parameter int WT_G = 151;
  parameter int WT_B = 28;
  parameter int N5 = 5;
  parameter int N6 = 6;
  parameter int N8 = 8;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } chan_t;

  typedef struct packed {
    logic swap;
    logic wide;
  } mode_t;
endpackage

// File: rtl/luma_stage.sv
module luma_stage
  import pixel_packer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  chan_t ch_i,
  input  logic  gray_i,
  input  mode_t mode_i,
  output logic  vld_o,
  output chan_t ch_o,
  output mode_t mode_o
);
  logic [SUM_W-1:0] prod_r, prod_g, prod_b, acc;
  logic [CH_W-1:0]  luma;
  chan_t            ch_d;

  always_comb begin
    prod_r = SUM_W'(ch_i.r) * SUM_W'(WT_R);
    prod_g = SUM_W'(ch_i.g) * SUM_W'(WT_G);
    prod_b = SUM_W'(ch_i.b) * SUM_W'(WT_B);
    acc    = prod_r + prod_g + prod_b;
    luma   = acc[SUM_W-1:FRAC_W];
    if (gray_i) begin
      ch_d.r = luma;
      ch_d.g = luma;
      ch_d.b = luma;
    end else begin
      ch_d = ch_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      ch_o   <= '0;
      mode_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        ch_o   <= ch_d;
        mode_o <= mode_i;
      end
    end
  end

  // R7: a gray sample leaves this stage with three equal channels
  p_gray_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && gray_i) |=> (ch_o.r == ch_o.g && ch_o.g == ch_o.b));

  // R7: all-ones inputs must not overflow the weighted sum
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && gray_i && (&ch_i.r) && (&ch_i.g) && (&ch_i.b)) |=> (&ch_o.g));
endmodule

// File: rtl/field_packer.sv
module field_packer
  import pixel_packer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  chan_t             ch_i,
  input  mode_t             mode_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);
  logic [N5-1:0]     r5, b5;
  logic [N6-1:0]     g6;
  logic [N8-1:0]     r8, g8, b8;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    r5 = ch_i.r[CH_W-1 -: N5];
    g6 = ch_i.g[CH_W-1 -: N6];
    b5 = ch_i.b[CH_W-1 -: N5];
    r8 = ch_i.r[CH_W-1 -: N8];
    g8 = ch_i.g[CH_W-1 -: N8];
    b8 = ch_i.b[CH_W-1 -: N8];
    unique case ({mode_i.wide, mode_i.swap})
      2'b00:   word_d = WORD_W'({r5, g6, b5});
      2'b01:   word_d = WORD_W'({b5, g6, r5});
      2'b10:   word_d = {r8, g8, b8};
      default: word_d = {b8, g8, r8};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      word_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) word_o <= word_d;
    end
  end

  // R8: narrow format never sets the top byte
  p_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !mode_i.wide) |=> (word_o[WORD_W-1:16] == '0));

  // R9: word holds while no sample is placed
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(word_o));

  // R3: narrow RGB puts red's top bits at the top of the 16-bit word
  p_red_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !mode_i.wide && !mode_i.swap) |=> (word_o[15:11] == $past(ch_i.r[CH_W-1 -: N5])));
endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
  import pixel_packer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_vld,
  input  logic [CH_W-1:0]   col_red,
  input  logic [CH_W-1:0]   col_grn,
  input  logic [CH_W-1:0]   col_blu,
  input  logic              gray_en,
  input  logic              swap_rb,
  input  logic              wide_fmt,
  output logic              pix_vld,
  output logic [WORD_W-1:0] pix_word
);
  chan_t ch_in, ch_mid;
  mode_t md_in, md_mid;
  logic  vld_mid;

  assign ch_in = '{r: col_red, g: col_grn, b: col_blu};
  assign md_in = '{swap: swap_rb, wide: wide_fmt};

  luma_stage u_luma (
    .clk(clk), .rst_n(rst_n), .vld_i(col_vld), .ch_i(ch_in), .gray_i(gray_en),
    .mode_i(md_in), .vld_o(vld_mid), .ch_o(ch_mid), .mode_o(md_mid)
  );

  field_packer u_pack (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_mid), .ch_i(ch_mid), .mode_i(md_mid),
    .vld_o(pix_vld), .word_o(pix_word)
  );

  // R1: an accepted sample yields a valid word two cycles later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    col_vld |=> ##1 pix_vld);

  // R1: no valid word without a sample two cycles earlier
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $past(col_vld, 2));
endmodule

// File: tb/test_pixel_packer.sv
`timescale 1ns/1ps
module test_pixel_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        col_vld;
  logic [15:0] col_red, col_grn, col_blu;
  logic        gray_en, swap_rb, wide_fmt;
  logic        pix_vld;
  logic [23:0] pix_word;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pixel_packer i_pixel_packer (
    .clk(clk), .rst_n(rst_n), .col_vld(col_vld), .col_red(col_red),
    .col_grn(col_grn), .col_blu(col_blu), .gray_en(gray_en), .swap_rb(swap_rb),
    .wide_fmt(wide_fmt), .pix_vld(pix_vld), .pix_word(pix_word)
  );

  function automatic logic [23:0] model(input logic [15:0] r, g, b,
                                        input logic gy, sw, wd);
    logic [31:0] y;
    logic [15:0] rr, gg, bb;
    rr = r; gg = g; bb = b;
    if (gy) begin
      y  = (32'd77 * r + 32'd151 * g + 32'd28 * b) >> 8;
      rr = y[15:0]; gg = y[15:0]; bb = y[15:0];
    end
    if (wd) model = sw ? {bb[15:8], gg[15:8], rr[15:8]} : {rr[15:8], gg[15:8], bb[15:8]};
    else    model = sw ? {8'h00, bb[15:11], gg[15:10], rr[15:11]}
                       : {8'h00, rr[15:11], gg[15:10], bb[15:11]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] r, g, b,
                       input logic gy, sw, wd);
    col_vld = v; col_red = r; col_grn = g; col_blu = b;
    gray_en = gy; swap_rb = sw; wide_fmt = wd;
  endtask

  // one sample, checked for latency and packing
  task automatic one_sample(input string req, input logic [15:0] r, g, b,
                            input logic gy, sw, wd);
    drive(1'b1, r, g, b, gy, sw, wd);
    @(negedge clk);
    drive(1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    check("R1 early", {31'd0, pix_vld}, 32'd0);
    @(negedge clk);
    check("R1 valid", {31'd0, pix_vld}, 32'd1);
    check(req, {8'd0, pix_word}, {8'd0, model(r, g, b, gy, sw, wd)});
    @(negedge clk);
    check("R1 single", {31'd0, pix_vld}, 32'd0);
  endtask

  task automatic t_reset;
    check("R2 vld", {31'd0, pix_vld}, 32'd0);
    check("R2 word", {8'd0, pix_word}, 32'd0);
  endtask

  task automatic t_formats;
    one_sample("R3", 16'hF800, 16'h07E0, 16'h001F, 1'b0, 1'b0, 1'b0);
    one_sample("R3", 16'hA5C3, 16'h3C96, 16'hE71B, 1'b0, 1'b0, 1'b0);
    one_sample("R4", 16'hA5C3, 16'h3C96, 16'hE71B, 1'b0, 1'b1, 1'b0);
    one_sample("R5", 16'h12FF, 16'hAB00, 16'h7734, 1'b0, 1'b0, 1'b1);
    one_sample("R6", 16'h12FF, 16'hAB00, 16'h7734, 1'b0, 1'b1, 1'b1);
    one_sample("R8", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_gray;
    one_sample("R7 ones", 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1);
    one_sample("R7 red", 16'h8000, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1);
    one_sample("R7 mix", 16'h1234, 16'hC0DE, 16'h9F00, 1'b1, 1'b1, 1'b0);
    one_sample("R7 zero", 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    logic [23:0] last;
    one_sample("R9 prime", 16'h4321, 16'h8765, 16'hCBA9, 1'b0, 1'b0, 1'b1);
    last = model(16'h4321, 16'h8765, 16'hCBA9, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 16'hFFFF - 16'(i), 16'h1111, 16'h2222, 1'(i), 1'b1, 1'b0);
      @(negedge clk);
      check("R9 vld", {31'd0, pix_vld}, 32'd0);
      check("R9 word", {8'd0, pix_word}, {8'd0, last});
    end
  endtask

  task automatic t_burst;
    logic [15:0] rr [4];
    logic [15:0] gg [4];
    logic [15:0] bb [4];
    logic [2:0]  md [4];
    rr = '{16'hFFFF, 16'h8000, 16'h5A5A, 16'h0F0F};
    gg = '{16'h0000, 16'h4000, 16'hA5A5, 16'hF0F0};
    bb = '{16'h1234, 16'hFFFF, 16'h3C3C, 16'h7E7E};
    md = '{3'b100, 3'b011, 3'b010, 3'b111};
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, rr[i], gg[i], bb[i], md[i][2], md[i][1], md[i][0]);
      @(negedge clk);
      if (i >= 1) begin
        check("R10 vld", {31'd0, pix_vld}, 32'd1);
        check("R10 word", {8'd0, pix_word},
              {8'd0, model(rr[i-1], gg[i-1], bb[i-1], md[i-1][2], md[i-1][1], md[i-1][0])});
      end
    end
    drive(1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 vld", {31'd0, pix_vld}, 32'd1);
    check("R10 last", {8'd0, pix_word}, {8'd0, model(rr[3], gg[3], bb[3], md[3][2], md[3][1], md[3][0])});
    @(negedge clk);
    check("R1 burst end", {31'd0, pix_vld}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_formats();
    t_gray();
    t_hold();
    t_burst();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule